// File: doc/BRIEF.md
# BCD Alarm Clock Controller

This block keeps the time of day as three two-digit BCD fields: hours, minutes and seconds. It also holds a second, independent set of fields for an alarm time. All of its registers run on one system clock. Two prescale counters inside the block make one-cycle enable pulses. One pulse marks each second. The other is a faster "set" pulse, used while a field is being adjusted.

Three adjust keys are shared between the running time and the alarm time. A mode bit decides which set they act on, and a single mode key flips that bit. The six display digits show whichever set the mode selects. A buzzer output sounds during two windows. The first is a short beep pattern just before each full hour. The second is the whole minute in which the running time equals the alarm hour and minute. The key inputs must already be debounced levels.

Top module: `bcd_alarm_clock`

## Requirements
- R1: A synchronous active-high reset sets the running time and the alarm time to 00:00:00 and sets mode 0, in which the display shows the running time.
- R2: Running seconds advance by one each SEC_DIV clock cycles. Seconds and minutes count 00 to 59, with the tens digit in the upper nibble and the units digit in the lower nibble of each field. A wrap from 59 to 00 advances the next higher field by one.
- R3: Running hours count 00 to 23 and then wrap to 00.
- R4: The mode bit flips once for each rising edge of the mode key, however long the key is held.
- R5: In mode 0, the running seconds read 00 for as long as the seconds key is held, and counting resumes after release.
- R6: In mode 0, while the minute key is held, running minutes advance once per set pulse (every SET_DIV cycles) and not on the seconds carry. The hour key does the same for hours.
- R7: In mode 1, each alarm field advances once per set pulse only while its own key is held. The alarm fields are not chained to each other, and no key changes the running time.
- R8: The display digits show the running time in mode 0 and the alarm time in mode 1. Changing mode leaves both the running count and the alarm setting unchanged.
- R9: The chime is high when running minutes read 59 and running seconds read 53, 55, 57 or 59, and it is low otherwise.
- R10: The alarm hit is high whenever running hours and minutes equal the alarm hours and minutes. Seconds play no part in this comparison, so the hit lasts a full minute, and it is also high at the 00:00 reset state.
- R11: The buzzer equals chime OR alarm hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| key_mode | input | 1 | Mode toggle key, debounced level |
| key_sec | input | 1 | Seconds adjust key |
| key_min | input | 1 | Minutes adjust key |
| key_hour | input | 1 | Hours adjust key |
| disp_hr_t | output | 4 | Hours tens digit shown |
| disp_hr_o | output | 4 | Hours units digit shown |
| disp_min_t | output | 4 | Minutes tens digit shown |
| disp_min_o | output | 4 | Minutes units digit shown |
| disp_sec_t | output | 4 | Seconds tens digit shown |
| disp_sec_o | output | 4 | Seconds units digit shown |
| chime | output | 1 | Pre-hour beep window |
| alarm_hit | output | 1 | Running hour and minute match the alarm |
| buzzer | output | 1 | Chime OR alarm hit |

## Verification
The assertions assume that the key inputs are clean levels that change only between rising edges, and that every press lasts at least one full cycle. They also assume that reset is held long enough to clear the prescalers. The bench changes every key and the reset only on the falling clock edge. It holds each adjust key for a whole number of set periods, so the expected field values follow from counting edges since reset. Mode presses are single-cycle pulses, except one press that is held for several cycles to check that the mode flips only once.

// File: rtl/bclk_pkg.sv
package bclk_pkg;
  typedef logic [7:0] bcd2_t;

  localparam bcd2_t SEC_LAST  = 8'h59;
  localparam bcd2_t HOUR_LAST = 8'h23;

  // next value of a two-digit BCD field that wraps after 'last'
  function automatic bcd2_t bcd2_next(bcd2_t v, bcd2_t last);
    if (v == last)          return 8'h00;
    if (v[3:0] == 4'd9)     return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // seconds values at which the pre-hour beep sounds: 53, 55, 57, 59
  function automatic logic beep_second(bcd2_t s);
    return (s[7:4] == 4'd5) && s[0] && (s[3:0] >= 4'd3) && (s[3:0] <= 4'd9);
  endfunction
endpackage

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] TOP = W'(DIV - 1);

  logic [W-1:0] cnt;

  assign tick = (cnt == TOP);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bcd_field.sv
module bcd_field import bclk_pkg::*; #(
  parameter bcd2_t LAST = 8'h59
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  clr,
  input  logic  inc,
  output bcd2_t val
);
  always_ff @(posedge clk) begin
    if (rst || clr) val <= 8'h00;
    else if (inc)   val <= bcd2_next(val, LAST);
  end
endmodule

// File: rtl/bcd_alarm_clock.sv
module bcd_alarm_clock import bclk_pkg::*; #(
  parameter int unsigned SEC_DIV = 50_000_000,
  parameter int unsigned SET_DIV = 12_500_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       key_mode,
  input  logic       key_sec,
  input  logic       key_min,
  input  logic       key_hour,
  output logic [3:0] disp_hr_t,
  output logic [3:0] disp_hr_o,
  output logic [3:0] disp_min_t,
  output logic [3:0] disp_min_o,
  output logic [3:0] disp_sec_t,
  output logic [3:0] disp_sec_o,
  output logic       chime,
  output logic       alarm_hit,
  output logic       buzzer
);
  logic sec_tick, set_tick;

  tick_gen #(.DIV(SEC_DIV)) u_sec_tick (.clk(clk), .rst(rst), .tick(sec_tick));
  tick_gen #(.DIV(SET_DIV)) u_set_tick (.clk(clk), .rst(rst), .tick(set_tick));

  // mode bit, toggled on the rising edge of the mode key
  logic mode, key_mode_q, mode_flip;
  assign mode_flip = key_mode & ~key_mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      key_mode_q <= 1'b0;
      mode       <= 1'b0;
    end else begin
      key_mode_q <= key_mode;
      if (mode_flip) mode <= ~mode;
    end
  end

  // running time
  bcd2_t run_sec, run_min, run_hr;
  logic  sec_clr, sec_carry, min_inc, min_carry, hr_inc;

  assign sec_clr   = ~mode & key_sec;
  assign sec_carry = sec_tick & ~sec_clr & (run_sec == SEC_LAST);
  assign min_inc   = (~mode & key_min) ? set_tick : sec_carry;
  assign min_carry = min_inc & (run_min == SEC_LAST);
  assign hr_inc    = (~mode & key_hour) ? set_tick : min_carry;

  bcd_field #(.LAST(SEC_LAST)) u_run_sec (
    .clk(clk), .rst(rst), .clr(sec_clr), .inc(sec_tick), .val(run_sec));
  bcd_field #(.LAST(SEC_LAST)) u_run_min (
    .clk(clk), .rst(rst), .clr(1'b0), .inc(min_inc), .val(run_min));
  bcd_field #(.LAST(HOUR_LAST)) u_run_hr (
    .clk(clk), .rst(rst), .clr(1'b0), .inc(hr_inc), .val(run_hr));

  // alarm time: index 0 seconds, 1 minutes, 2 hours; unchained
  logic [2:0] al_key;
  bcd2_t      al_val [3];
  assign al_key = {key_hour, key_min, key_sec};

  for (genvar g = 0; g < 3; g++) begin : g_alarm
    localparam bcd2_t LAST = (g == 2) ? HOUR_LAST : SEC_LAST;
    bcd_field #(.LAST(LAST)) u_fld (
      .clk(clk), .rst(rst), .clr(1'b0),
      .inc(mode & al_key[g] & set_tick), .val(al_val[g]));
  end

  // display selection
  bcd2_t show_hr, show_min, show_sec;
  assign show_hr  = mode ? al_val[2] : run_hr;
  assign show_min = mode ? al_val[1] : run_min;
  assign show_sec = mode ? al_val[0] : run_sec;

  assign disp_hr_t  = show_hr[7:4];
  assign disp_hr_o  = show_hr[3:0];
  assign disp_min_t = show_min[7:4];
  assign disp_min_o = show_min[3:0];
  assign disp_sec_t = show_sec[7:4];
  assign disp_sec_o = show_sec[3:0];

  // sound sources
  assign chime     = (run_min == SEC_LAST) && beep_second(run_sec);
  assign alarm_hit = (run_hr == al_val[2]) && (run_min == al_val[1]);
  assign buzzer    = chime | alarm_hit;
endmodule

// File: rtl/bclk_chk.sv
module bclk_chk (
  input logic       clk,
  input logic       rst,
  input logic       mode,
  input logic       mode_flip,
  input logic       sec_clr,
  input logic       sec_carry,
  input logic [7:0] run_sec,
  input logic [7:0] run_min,
  input logic [7:0] run_hr,
  input logic [7:0] al_sec,
  input logic [7:0] al_min,
  input logic [7:0] al_hr,
  input logic       chime,
  input logic       alarm_hit,
  input logic       buzzer
);
  // R2
  sec_min_range_chk: assert property (@(posedge clk) disable iff (rst)
    run_sec[3:0] <= 4'd9 && run_sec <= 8'h59 && run_min[3:0] <= 4'd9 && run_min <= 8'h59);

  // R2
  sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    sec_carry |=> run_sec == 8'h00);

  // R3
  hour_range_chk: assert property (@(posedge clk) disable iff (rst)
    run_hr[3:0] <= 4'd9 && run_hr <= 8'h23);

  // R4
  mode_flip_chk: assert property (@(posedge clk) disable iff (rst)
    mode_flip |=> mode != $past(mode));

  // R4
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_flip |=> $stable(mode));

  // R5
  sec_clear_chk: assert property (@(posedge clk) disable iff (rst)
    sec_clr |=> run_sec == 8'h00);

  // R7
  alarm_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !mode |=> $stable(al_sec) && $stable(al_min) && $stable(al_hr));

  // R9
  chime_window_chk: assert property (@(posedge clk) disable iff (rst)
    chime |-> run_min == 8'h59 && run_sec[0] && run_sec[7:4] == 4'd5);

  // R10
  alarm_equal_chk: assert property (@(posedge clk) disable iff (rst)
    alarm_hit |-> run_hr == al_hr && run_min == al_min);

  // R11
  buzzer_on_chk: assert property (@(posedge clk) disable iff (rst)
    (chime || alarm_hit) |-> buzzer);

  // R11
  buzzer_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!chime && !alarm_hit) |-> !buzzer);
endmodule

bind bcd_alarm_clock bclk_chk u_chk (
  .clk(clk), .rst(rst), .mode(mode), .mode_flip(mode_flip),
  .sec_clr(sec_clr), .sec_carry(sec_carry),
  .run_sec(run_sec), .run_min(run_min), .run_hr(run_hr),
  .al_sec(al_val[0]), .al_min(al_val[1]), .al_hr(al_val[2]),
  .chime(chime), .alarm_hit(alarm_hit), .buzzer(buzzer)
);

// File: tb/sim_bcd_alarm_clock.sv
module sim_bcd_alarm_clock;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic key_mode = 1'b0, key_sec = 1'b0, key_min = 1'b0, key_hour = 1'b0;
  logic [3:0] h_t, h_o, m_t, m_o, s_t, s_o;
  logic chime, alarm_hit, buzzer;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bcd_alarm_clock #(.SEC_DIV(4), .SET_DIV(2)) u0 (
    .clk(clk), .rst(rst), .key_mode(key_mode), .key_sec(key_sec),
    .key_min(key_min), .key_hour(key_hour),
    .disp_hr_t(h_t), .disp_hr_o(h_o), .disp_min_t(m_t), .disp_min_o(m_o),
    .disp_sec_t(s_t), .disp_sec_o(s_o),
    .chime(chime), .alarm_hit(alarm_hit), .buzzer(buzzer));

  function automatic logic [23:0] shown();
    return {h_t, h_o, m_t, m_o, s_t, s_o};
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_time(string req, logic [23:0] exp);
    checks++;
    if (shown() !== exp) begin
      errors++;
      $display("FAIL %s display got %h expected %h", req, shown(), exp);
    end
  endtask

  task automatic chk_bit(string req, string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    key_mode = 1'b0; key_sec = 1'b0; key_min = 1'b0; key_hour = 1'b0;
    step(2);
    rst = 1'b0;
  endtask

  task automatic toggle();
    key_mode = 1'b1; step(1);
    key_mode = 1'b0; step(1);
  endtask

  // R1: reset clears time, alarm and mode
  task automatic t_reset();
    do_reset();
    toggle();
    key_min = 1'b1; step(4); key_min = 1'b0;
    rst = 1'b1; step(2);
    chk_time("R1", 24'h000000);
    rst = 1'b0;
    chk_bit("R10", "alarm_hit at 00:00", alarm_hit, 1'b1);
    chk_bit("R11", "buzzer at reset match", buzzer, 1'b1);
    toggle();
    chk_time("R1", 24'h000000);
  endtask

  // R2: seconds count and carry into minutes
  task automatic t_count();
    do_reset();
    step(236);
    chk_time("R2", 24'h000059);
    step(8);
    chk_time("R2", 24'h000101);
  endtask

  // R6, R9, R11, R2: fast minute set, then chime and hour carry
  task automatic t_chime();
    do_reset();
    key_min = 1'b1; step(118); key_min = 1'b0;
    chk_time("R6", 24'h005929);
    step(94);
    chk_time("R2", 24'h005953);
    chk_bit("R9", "chime at 59:53", chime, 1'b1);
    chk_bit("R11", "buzzer with chime", buzzer, 1'b1);
    step(4);
    chk_bit("R9", "chime at 59:54", chime, 1'b0);
    chk_bit("R11", "buzzer quiet", buzzer, 1'b0);
    step(4);
    chk_bit("R9", "chime at 59:55", chime, 1'b1);
    step(20);
    chk_time("R2", 24'h010000);
    chk_bit("R9", "chime at 00:00", chime, 1'b0);
  endtask

  // R3, R6: fast hour set and 23 -> 00 wrap
  task automatic t_hours();
    do_reset();
    key_hour = 1'b1; step(46);
    chk_time("R3", 24'h230011);
    step(2); key_hour = 1'b0;
    chk_time("R3", 24'h000012);
  endtask

  // R5: seconds key holds running seconds at 00
  task automatic t_sec_clear();
    do_reset();
    step(40);
    chk_time("R5", 24'h000010);
    key_sec = 1'b1; step(1);
    chk_time("R5", 24'h000000);
    step(8);
    chk_time("R5", 24'h000000);
    key_sec = 1'b0; step(3);
    chk_time("R5", 24'h000001);
  endtask

  // R4: long press flips mode once
  task automatic t_mode_hold();
    do_reset();
    step(20);
    chk_time("R4", 24'h000005);
    key_mode = 1'b1; step(6);
    chk_time("R4", 24'h000000);
    key_mode = 1'b0; step(2);
    chk_time("R4", 24'h000000);
  endtask

  // R7, R8: alarm set in mode 1, running untouched, alarm retained
  task automatic t_alarm_set();
    do_reset();
    toggle();
    key_min = 1'b1; step(10); key_min = 1'b0;
    key_hour = 1'b1; step(6); key_hour = 1'b0;
    key_sec = 1'b1; step(8); key_sec = 1'b0;
    chk_time("R7", 24'h030504);
    toggle();
    chk_time("R8", 24'h000007);
    chk_bit("R10", "no match", alarm_hit, 1'b0);
    toggle();
    chk_time("R8", 24'h030504);
  endtask

  // R10, R11: match lasts the whole minute
  task automatic t_alarm_match();
    do_reset();
    toggle();
    key_min = 1'b1; step(2); key_min = 1'b0;
    toggle();
    chk_time("R8", 24'h000001);
    chk_bit("R10", "before minute", alarm_hit, 1'b0);
    step(234);
    chk_time("R10", 24'h000100);
    chk_bit("R10", "minute start", alarm_hit, 1'b1);
    chk_bit("R11", "buzzer with alarm", buzzer, 1'b1);
    step(236);
    chk_bit("R10", "minute end", alarm_hit, 1'b1);
    step(4);
    chk_time("R10", 24'h000200);
    chk_bit("R10", "after minute", alarm_hit, 1'b0);
    chk_bit("R11", "buzzer off", buzzer, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    finish_run();
  end

  initial begin
    t_reset();
    t_count();
    t_chime();
    t_hours();
    t_sec_clear();
    t_mode_hold();
    t_alarm_set();
    t_alarm_match();
    finish_run();
  end
endmodule